// File: doc/BRIEF.md
# Descriptor Ring Position Counter

This block keeps track of which descriptor a DMA engine is working on inside a circular ring of descriptors. One instance serves the receive ring and a second instance serves the transmit ring. Each instance holds two 16-bit registers. The length register holds the ring size as a negative number: the two's complement of the number of descriptors. The position register holds the current descriptor, counted upward from that negative value. Its final descriptor is the all-ones value (minus one).

At controller start-up an initialization pulse converts a 3-bit size exponent into the negative length and places the position on the first descriptor. Each advance strobe moves to the next descriptor, and the move from the final descriptor wraps back to the first. Software may read both registers at any time. It may write them only while the engine is stopped or suspended. Because the length is always taken from the register's present value, a rewritten length governs the next wrap. For convenience the block also outputs a zero-based index and a flag for the final descriptor.

Top module: `drpc_ring_pos`

## Requirements
- R1: After reset both the length register and the position register read FFFFh (a one-entry ring), index_o is 0 and last_o is 1.
- R2: A cycle with init_i high loads the length register with the two's complement of 2^len_code_i (code 0..7 gives 1..128 descriptors) and sets the position to that same value on the next edge; init_i overrides any write or advance in the same cycle.
- R3: An advance_i strobe while the position is not FFFFh increments the position by one at the next edge.
- R4: An advance_i strobe while the position is FFFFh reloads the position from the current length register at the next edge.
- R5: last_o is 1 exactly when the position register holds FFFFh.
- R6: index_o equals the position minus the length register, modulo 2^16.
- R7: While stop_i or suspend_i is high, reg_wr_i writes reg_wdata_i into the register chosen by reg_sel_i (0 = position, 1 = length) at the next edge; a position write takes priority over an advance in the same cycle.
- R8: While both stop_i and suspend_i are low, reg_wr_i changes neither register, and an advance in the same cycle still steps the position.
- R9: reg_rdata_o shows the position when reg_sel_i is 0 and the length when reg_sel_i is 1, in every state, without a clock delay.
- R10: A length written by software after initialization sets the reload value used at the next wrap from FFFFh.
- R11: With no init, write or advance in a cycle, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Engine stopped; permits register writes |
| suspend_i | input | 1 | Engine suspended; permits register writes |
| init_i | input | 1 | Initialization pulse: load length from the code, position to first descriptor |
| len_code_i | input | 3 | Ring size exponent: ring holds 2^code descriptors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 position, 1 length |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register |
| advance_i | input | 1 | Step to the next descriptor |
| index_o | output | 16 | Zero-based descriptor index |
| last_o | output | 1 | Position is on the final descriptor |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 3-bit size exponent. These values reach both extremes of the ring size. At a size of one, the position stays on FFFFh and wraps onto itself. At a size of 128, the first descriptor is FF80h. The bench also covers a four-entry ring that is stepped all the way to FFFFh and around. Same-cycle collisions are included: init with a write, a write with an advance, and a blocked write with an advance. These cover the priority rules and the gating by the stop and suspend inputs.

// File: rtl/drpc_pkg.sv
`timescale 1ns/1ps
package drpc_pkg;
  localparam int unsigned DRPC_WIDTH  = 16;
  localparam int unsigned DRPC_CODE_W = 3;

  typedef enum logic {
    SEL_POS = 1'b0,
    SEL_LEN = 1'b1
  } drpc_sel_e;
endpackage

// File: rtl/drpc_access_gate.sv
`timescale 1ns/1ps
module drpc_access_gate
  import drpc_pkg::*;
(
  input  logic      stop_i,
  input  logic      suspend_i,
  input  logic      init_i,
  input  logic      reg_wr_i,
  input  drpc_sel_e reg_sel_i,
  output logic      wr_pos_o,
  output logic      wr_len_o
);
  logic access_open;

  // Writes reach the registers only while halted; init owns the cycle.
  assign access_open = (stop_i | suspend_i) & ~init_i;
  assign wr_pos_o    = access_open & reg_wr_i & (reg_sel_i == SEL_POS);
  assign wr_len_o    = access_open & reg_wr_i & (reg_sel_i == SEL_LEN);
endmodule

// File: rtl/drpc_len_reg.sv
`timescale 1ns/1ps
module drpc_len_reg #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  init_val_o,
  output logic [WIDTH-1:0]  len_o
);
  localparam logic [WIDTH-1:0] ONE_RING = '1;

  // Negated descriptor count for a ring of 2^code entries.
  function automatic logic [WIDTH-1:0] neg_ring_len(input logic [CODE_W-1:0] code);
    logic [WIDTH-1:0] count;
    count = WIDTH'(1) << code;
    return ~count + WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] len_q;

  assign init_val_o = neg_ring_len(code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= ONE_RING;
    else if (init_i) len_q <= init_val_o;
    else if (wr_i)   len_q <= wdata_i;
  end

  assign len_o = len_q;
endmodule

// File: rtl/drpc_pos_ctr.sv
`timescale 1ns/1ps
module drpc_pos_ctr #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [WIDTH-1:0] init_val_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] len_i,
  output logic [WIDTH-1:0] pos_o,
  output logic             last_o,
  output logic             step_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] LAST_POS = '1;

  // Successor of a position inside a ring whose first entry is len.
  function automatic logic [WIDTH-1:0] next_pos(input logic [WIDTH-1:0] pos,
                                                input logic [WIDTH-1:0] len);
    return (pos == LAST_POS) ? len : pos + WIDTH'(1);
  endfunction

  logic [WIDTH-1:0] pos_q;
  logic             adv_live;

  assign last_o   = (pos_q == LAST_POS);
  assign adv_live = adv_i & ~init_i & ~wr_i;
  assign step_o   = adv_live & ~last_o;
  assign wrap_o   = adv_live &  last_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= LAST_POS;
    else if (init_i)   pos_q <= init_val_i;
    else if (wr_i)     pos_q <= wdata_i;
    else if (adv_live) pos_q <= next_pos(pos_q, len_i);
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/drpc_ring_pos.sv
`timescale 1ns/1ps
module drpc_ring_pos
  import drpc_pkg::*;
#(
  parameter int unsigned WIDTH  = DRPC_WIDTH,
  parameter int unsigned CODE_W = DRPC_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              suspend_i,
  input  logic              init_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  input  logic              advance_i,
  output logic [WIDTH-1:0]  index_o,
  output logic              last_o
);
  // Zero-based index: distance of the position from the first descriptor.
  function automatic logic [WIDTH-1:0] zero_index(input logic [WIDTH-1:0] pos,
                                                  input logic [WIDTH-1:0] len);
    return pos - len;
  endfunction

  drpc_sel_e        sel;
  logic             wr_pos_ok;
  logic             wr_len_ok;
  logic             step_evt;
  logic             wrap_evt;
  logic [WIDTH-1:0] init_val;
  logic [WIDTH-1:0] len_q;
  logic [WIDTH-1:0] pos_q;

  assign sel = drpc_sel_e'(reg_sel_i);

  drpc_access_gate u_gate (
    .stop_i    (stop_i),
    .suspend_i (suspend_i),
    .init_i    (init_i),
    .reg_wr_i  (reg_wr_i),
    .reg_sel_i (sel),
    .wr_pos_o  (wr_pos_ok),
    .wr_len_o  (wr_len_ok)
  );

  drpc_len_reg #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .code_i     (len_code_i),
    .wr_i       (wr_len_ok),
    .wdata_i    (reg_wdata_i),
    .init_val_o (init_val),
    .len_o      (len_q)
  );

  drpc_pos_ctr #(.WIDTH(WIDTH)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .init_val_i (init_val),
    .wr_i       (wr_pos_ok),
    .wdata_i    (reg_wdata_i),
    .adv_i      (advance_i),
    .len_i      (len_q),
    .pos_o      (pos_q),
    .last_o     (last_o),
    .step_o     (step_evt),
    .wrap_o     (wrap_evt)
  );

  assign reg_rdata_o = (sel == SEL_LEN) ? len_q : pos_q;
  assign index_o     = zero_index(pos_q, len_q);
endmodule

// File: rtl/drpc_ring_pos_chk.sv
`timescale 1ns/1ps
module drpc_ring_pos_chk #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              suspend_i,
  input logic              init_i,
  input logic [CODE_W-1:0] len_code_i,
  input logic              reg_wr_i,
  input logic [WIDTH-1:0]  reg_wdata_i,
  input logic              advance_i,
  input logic [WIDTH-1:0]  index_o,
  input logic              last_o,
  input logic [WIDTH-1:0]  pos_q,
  input logic [WIDTH-1:0]  len_q,
  input logic              wr_pos_ok,
  input logic              step_evt,
  input logic              wrap_evt
);
  AST_INIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (len_q + (WIDTH'(1) << $past(len_code_i))) == '0); // R2
  AST_INIT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> pos_q == len_q); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> pos_q == $past(pos_q) + WIDTH'(1)); // R3
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pos_q == $past(len_q)); // R4
  AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> index_o == ~len_q); // R5
  AST_POS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pos_ok |=> pos_q == $past(reg_wdata_i)); // R7
  AST_NO_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !stop_i && !suspend_i && !init_i && !advance_i)
      |=> ($stable(pos_q) && $stable(len_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !reg_wr_i && !advance_i) |=> ($stable(pos_q) && $stable(len_q))); // R11
endmodule

bind drpc_ring_pos drpc_ring_pos_chk #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .suspend_i   (suspend_i),
  .init_i      (init_i),
  .len_code_i  (len_code_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .advance_i   (advance_i),
  .index_o     (index_o),
  .last_o      (last_o),
  .pos_q       (pos_q),
  .len_q       (len_q),
  .wr_pos_ok   (wr_pos_ok),
  .step_evt    (step_evt),
  .wrap_evt    (wrap_evt)
);

// File: tb/drpc_ring_pos_test.sv
`timescale 1ns/1ps
module drpc_ring_pos_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_i = 1'b0, suspend_i = 1'b0, init_i = 1'b0;
  logic [2:0]  len_code_i = '0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0, advance_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o, index_o;
  logic        last_o;

  always #2.5 clk = ~clk;

  drpc_ring_pos uut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .suspend_i(suspend_i),
    .init_i(init_i), .len_code_i(len_code_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .advance_i(advance_i), .index_o(index_o), .last_o(last_o)
  );

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic [15:0] idx;
    logic        lst;
  } exp_t;

  exp_t        sb[$];
  int          compared = 0;
  int          mismatched = 0;
  logic [15:0] m_pos = 16'hFFFF;
  logic [15:0] m_len = 16'hFFFF;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what the ports must show after it.
  task automatic drive(string tag, bit ini, logic [2:0] code, bit wr, bit sel,
                       logic [15:0] wd, bit adv);
    exp_t        e;
    logic [15:0] n_pos, n_len;
    bit          open;
    @(negedge clk);
    init_i = ini; len_code_i = code; reg_wr_i = wr; reg_sel_i = sel;
    reg_wdata_i = wd; advance_i = adv;
    n_pos = m_pos; n_len = m_len;
    open = stop_i || suspend_i;
    if (ini) begin
      n_len = 16'(32'h10000 - (32'd1 << code));
      n_pos = n_len;
    end else begin
      if (wr && open && sel) n_len = wd;
      if (wr && open && !sel) n_pos = wd;
      else if (adv) n_pos = (m_pos === 16'hFFFF) ? m_len : 16'(m_pos + 16'd1);
    end
    m_pos = n_pos; m_len = n_len;
    e.tag = tag;
    e.rd  = sel ? m_len : m_pos;
    e.idx = 16'(m_pos - m_len);
    e.lst = (m_pos === 16'hFFFF);
    sb.push_back(e);
    @(posedge clk);
    #1;
    init_i = 1'b0; reg_wr_i = 1'b0; advance_i = 1'b0;
  endtask

  // Monitor: compares queued expectations after each clock edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "rdata", reg_rdata_o, e.rd);
      check(e.tag, "index", index_o, e.idx);
      check(e.tag, "last", {15'd0, last_o}, {15'd0, e.lst});
    end
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #12;
    // R1: reset state
    check("R1", "pos", reg_rdata_o, 16'hFFFF);
    check("R1", "index", index_o, 16'h0000);
    check("R1", "last", {15'd0, last_o}, 16'd1);
    reg_sel_i = 1'b1; #1;
    check("R1", "len", reg_rdata_o, 16'hFFFF);
    reg_sel_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R2: four-entry ring, then step R3 up to last R5, wrap R4
    drive("R2", 1, 3'd2, 0, 0, 0, 0);
    drive("R2", 0, 3'd0, 0, 1, 0, 0);
    drive("R3", 0, 3'd0, 0, 0, 0, 1);
    drive("R3", 0, 3'd0, 0, 0, 0, 1);
    drive("R5", 0, 3'd0, 0, 0, 0, 1);
    drive("R4", 0, 3'd0, 0, 0, 0, 1);
    drive("R11", 0, 3'd0, 0, 0, 0, 0);
    drive("R6", 0, 3'd0, 0, 0, 0, 1);
    // R2: largest ring and single-entry ring
    drive("R2", 1, 3'd7, 0, 1, 0, 0);
    drive("R6", 0, 3'd0, 0, 0, 0, 1);
    drive("R2", 1, 3'd0, 0, 0, 0, 0);
    drive("R4", 0, 3'd0, 0, 0, 0, 1);
    // R8: writes blocked while running, advance still works
    drive("R2", 1, 3'd3, 0, 0, 0, 0);
    drive("R8", 0, 3'd0, 1, 0, 16'h1234, 0);
    drive("R8", 0, 3'd0, 1, 1, 16'h00F0, 0);
    drive("R8", 0, 3'd0, 1, 0, 16'h5555, 1);
    // R7: writes while suspended, position write beats advance
    @(negedge clk); suspend_i = 1'b1;
    drive("R7", 0, 3'd0, 1, 1, 16'hFFF8, 0);
    drive("R7", 0, 3'd0, 1, 0, 16'hFFFE, 1);
    drive("R9", 0, 3'd0, 0, 1, 0, 0);
    drive("R9", 0, 3'd0, 0, 0, 0, 0);
    // R10: rewritten length is the next reload value
    drive("R7", 0, 3'd0, 1, 1, 16'hFFFA, 0);
    drive("R3", 0, 3'd0, 0, 0, 0, 1);
    drive("R10", 0, 3'd0, 0, 0, 0, 1);
    @(negedge clk); suspend_i = 1'b0; stop_i = 1'b1;
    drive("R7", 0, 3'd0, 1, 0, 16'hFFFF, 0);
    // R2: init overrides a permitted write and an advance
    drive("R2", 1, 3'd1, 1, 1, 16'h0000, 1);
    drive("R2", 0, 3'd0, 0, 0, 0, 0);
    drive("R11", 0, 3'd0, 0, 1, 0, 0);
    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule